// File: doc/BRIEF.md
# Three-Pair Motor PWM Generator

The block drives three half-bridges. One shared time base counts either as a sawtooth (edge-aligned) or as a triangle (center-aligned). Each half-bridge has its own duty value. The duty value is compared against the shared count to give a raw switch command. A dead-band stage then splits that command into a high-side and a low-side gate signal, with a programmable guard interval at every transition.

Period and duty values are written into shadow registers. They reach the compare logic only at a reload boundary, which falls once every 1 to 16 periods. Each reload sets a sticky interrupt flag that software clears. Each period start emits a one-cycle pulse that lets a converter sample in step with the modulation.

An external fault line is synchronised and latched. While the latch is set, a selectable set of gate outputs is held off. The latch releases only at a period start after the line has returned low. The dead interval and the fault mask each accept one write after reset and ignore any later write.

Software writes registers through a single write strobe carrying a 3-bit address and 16-bit data.

Top module: `mcpwm_top`

## Requirements
- R1: After reset, all six gate outputs, the interrupt flag and the sync pulse are low.
- R2: With register 0 bit 1 clear (edge-aligned), a period lasts P cycles, where P is register 1. The high-side output of pair k (pwm_out[2k]) is active d cycles per period when duty d (register 2+k) is below P. The low-side output (pwm_out[2k+1]) is active for the rest of the period when the dead interval is 0.
- R3: With register 0 bit 1 set (center-aligned), the count rises from 0 to P and falls back, so a period lasts 2P cycles. The high-side output is active 2d-1 cycles per period for 1 <= d < P.
- R4: Duty 0 keeps the high-side output inactive for the whole period. A duty of at least P keeps it active for the whole period, in both modes.
- R5: The two outputs of a pair are never active together. With a dead interval t (register 5), each transition leaves both outputs inactive for t cycles, so per period the high side loses t cycles and the low side loses t cycles.
- R6: Writes to period and duty registers change the outputs only after the next reload.
- R7: A reload occurs at the end of every N-th period, where register 0 bits [5:2] hold N-1. Each reload sets the interrupt flag in the same cycle as the sync pulse.
- R8: Writing register 7 with bit 0 set clears the interrupt flag. If a reload falls in the same cycle as the clear, the flag stays set.
- R9: While the latched fault is set, each output whose bit is set in register 6 is forced inactive. Bit 2k selects the high side of pair k and bit 2k+1 selects the low side. The fault input passes two synchronising flip-flops before the latch.
- R10: After the fault input returns low, masked outputs stay inactive until the next period start.
- R11: The dead interval and the fault mask each take only the first write after reset. Later writes are ignored.
- R12: With register 0 bit 0 clear, all outputs are inactive and no sync pulse is produced.
- R13: The sync output is a single-cycle pulse at the first cycle of every period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| fault_in | input | 1 | External fault, active high, asynchronous |
| pwm_out | output | 6 | Gate outputs; bit 2k high side, bit 2k+1 low side of pair k |
| adc_sync | output | 1 | One-cycle period-start pulse |
| reload_irq | output | 1 | Sticky reload interrupt flag |

## Verification
A reload can set the interrupt flag on the same clock edge on which software clears it. The bench provokes this by counting cycles from an observed sync pulse, with a reload at every period. It places the clear write exactly on the edge of the next period start and expects the flag to remain set. A clear one cycle later is expected to take effect. The latched fault and a period start also meet when the fault line falls just before a period boundary. The bench judges that case by checking that the masked outputs stay off during the rest of the period and come back only after the following sync pulse.

// File: rtl/mcpwm_pkg.sv
`timescale 1ns/1ps
package mcpwm_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned RL_W   = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd1;
  localparam logic [ADDR_W-1:0] A_DUTY0  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DEAD   = 3'd5;
  localparam logic [ADDR_W-1:0] A_FMASK  = 3'd6;
  localparam logic [ADDR_W-1:0] A_IRQCLR = 3'd7;

  typedef struct packed {
    logic [RL_W-1:0] rl_sel;
    logic            center;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/mcpwm_regs.sv
`timescale 1ns/1ps
module mcpwm_regs
  import mcpwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DT_W   = 4,
  parameter int unsigned NPAIR  = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic                          reload_i,
  output ctrl_t                         ctrl_o,
  output logic [CNT_W-1:0]              period_o,
  output logic [NPAIR-1:0][CNT_W-1:0]   duty_o,
  output logic [DT_W-1:0]               dead_o,
  output logic                          dead_lock_o,
  output logic [2*NPAIR-1:0]            fmask_o,
  output logic                          irq_o
);
  localparam int unsigned NOUT = 2 * NPAIR;

  ctrl_t                        ctrl_q, ctrl_d;
  logic [CNT_W-1:0]             period_q, period_d;
  logic [NPAIR-1:0][CNT_W-1:0]  duty_q, duty_d;
  logic [DT_W-1:0]              dead_q, dead_d;
  logic                         dlock_q, dlock_d;
  logic [NOUT-1:0]              fmask_q, fmask_d;
  logic                         flock_q, flock_d;
  logic                         irq_q, irq_d;
  logic                         clr_hit;
  logic                         unused_data;

  assign unused_data = ^wr_data;
  assign clr_hit = wr_en && (wr_addr == A_IRQCLR) && wr_data[0];

  always_comb begin
    ctrl_d   = ctrl_q;
    period_d = period_q;
    duty_d   = duty_q;
    dead_d   = dead_q;
    dlock_d  = dlock_q;
    fmask_d  = fmask_q;
    flock_d  = flock_q;
    if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        ctrl_d.en     = wr_data[0];
        ctrl_d.center = wr_data[1];
        ctrl_d.rl_sel = wr_data[2 +: RL_W];
      end
      if (wr_addr == A_PERIOD) period_d = wr_data[CNT_W-1:0];
      for (int k = 0; k < NPAIR; k++) begin
        if (wr_addr == A_DUTY0 + ADDR_W'(k)) duty_d[k] = wr_data[CNT_W-1:0];
      end
      if ((wr_addr == A_DEAD) && !dlock_q) begin
        dead_d  = wr_data[DT_W-1:0];
        dlock_d = 1'b1;
      end
      if ((wr_addr == A_FMASK) && !flock_q) begin
        fmask_d = wr_data[NOUT-1:0];
        flock_d = 1'b1;
      end
    end
    // A reload on the same edge as a clear keeps the flag set.
    if (reload_i)     irq_d = 1'b1;
    else if (clr_hit) irq_d = 1'b0;
    else              irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '0;
      duty_q   <= '0;
      dead_q   <= '0;
      dlock_q  <= 1'b0;
      fmask_q  <= '0;
      flock_q  <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      period_q <= period_d;
      duty_q   <= duty_d;
      dead_q   <= dead_d;
      dlock_q  <= dlock_d;
      fmask_q  <= fmask_d;
      flock_q  <= flock_d;
      irq_q    <= irq_d;
    end
  end

  assign ctrl_o      = ctrl_q;
  assign period_o    = period_q;
  assign duty_o      = duty_q;
  assign dead_o      = dead_q;
  assign dead_lock_o = dlock_q;
  assign fmask_o     = fmask_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/mcpwm_timebase.sv
`timescale 1ns/1ps
module mcpwm_timebase
  import mcpwm_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned NPAIR = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en_i,
  input  logic                         center_i,
  input  logic [RL_W-1:0]              rl_sel_i,
  input  logic [CNT_W-1:0]             period_buf_i,
  input  logic [NPAIR-1:0][CNT_W-1:0]  duty_buf_i,
  output logic                         wrap_o,
  output logic                         reload_o,
  output logic                         sync_o,
  output logic [NPAIR-1:0]             raw_o
);
  logic [CNT_W-1:0]             cnt_q, cnt_d;
  logic                         up_q, up_d;
  logic [RL_W-1:0]              rl_q, rl_d;
  logic [CNT_W-1:0]             per_q, per_d;
  logic [NPAIR-1:0][CNT_W-1:0]  duty_q, duty_d;
  logic                         sync_q;
  logic [NPAIR-1:0]             raw_q, raw_d;
  logic [CNT_W:0]               cnt_inc;
  logic                         wrap, reload;

  assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

  // Counter sequencing: sawtooth or triangle.
  always_comb begin
    wrap  = 1'b0;
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!en_i) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (per_q == '0) begin
      wrap  = 1'b1;
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (!center_i) begin
      up_d = 1'b1;
      if (cnt_inc >= {1'b0, per_q}) begin
        wrap  = 1'b1;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end else if (up_q) begin
      cnt_d = cnt_inc[CNT_W-1:0];
      if (cnt_inc >= {1'b0, per_q}) up_d = 1'b0;
    end else if (cnt_q <= CNT_W'(1)) begin
      wrap  = 1'b1;
      cnt_d = '0;
      up_d  = 1'b1;
    end else begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  // Reload interval and shadow transfer.
  always_comb begin
    reload = wrap && (rl_q >= rl_sel_i);
    rl_d   = rl_q;
    per_d  = per_q;
    duty_d = duty_q;
    if (!en_i) begin
      rl_d = '0;
    end else if (wrap) begin
      rl_d = reload ? '0 : rl_q + RL_W'(1);
    end
    if (!en_i || reload) begin
      per_d  = period_buf_i;
      duty_d = duty_buf_i;
    end
  end

  // Duty comparison per pair.
  always_comb begin
    for (int k = 0; k < NPAIR; k++) begin
      raw_d[k] = en_i && ((duty_q[k] >= per_q) || (cnt_q < duty_q[k]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      up_q   <= 1'b1;
      rl_q   <= '0;
      per_q  <= '0;
      duty_q <= '0;
      sync_q <= 1'b0;
      raw_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      up_q   <= up_d;
      rl_q   <= rl_d;
      per_q  <= per_d;
      duty_q <= duty_d;
      sync_q <= wrap;
      raw_q  <= raw_d;
    end
  end

  assign wrap_o   = wrap;
  assign reload_o = reload;
  assign sync_o   = sync_q;
  assign raw_o    = raw_q;
endmodule

// File: rtl/mcpwm_deadband.sv
`timescale 1ns/1ps
module mcpwm_deadband #(
  parameter int unsigned DT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            raw_i,
  input  logic [DT_W-1:0] dead_i,
  output logic            hi_o,
  output logic            lo_o
);
  logic            prev_q;
  logic [DT_W-1:0] gap_q, gap_d;
  logic            hi_q, hi_d, lo_q, lo_d;

  always_comb begin
    if (raw_i != prev_q)   gap_d = dead_i;
    else if (gap_q != '0)  gap_d = gap_q - DT_W'(1);
    else                   gap_d = gap_q;
    hi_d =  raw_i && (gap_d == '0);
    lo_d = !raw_i && (gap_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      gap_q  <= '0;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      prev_q <= raw_i;
      gap_q  <= gap_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/mcpwm_fault.sv
`timescale 1ns/1ps
module mcpwm_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_i,
  input  logic pstart_i,
  output logic active_o
);
  logic s1_q, s2_q, lat_q, lat_d;

  always_comb begin
    if (s2_q)          lat_d = 1'b1;
    else if (pstart_i) lat_d = 1'b0;
    else               lat_d = lat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      s1_q  <= fault_i;
      s2_q  <= s1_q;
      lat_q <= lat_d;
    end
  end

  assign active_o = lat_q;
endmodule

// File: rtl/mcpwm_top.sv
`timescale 1ns/1ps
module mcpwm_top
  import mcpwm_pkg::*;
#(
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned DT_W   = 4,
  parameter int unsigned NPAIR  = 3,
  parameter int unsigned DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 fault_in,
  output logic [2*NPAIR-1:0]   pwm_out,
  output logic                 adc_sync,
  output logic                 reload_irq
);
  localparam int unsigned NOUT = 2 * NPAIR;

  ctrl_t                        ctrl_w;
  logic [CNT_W-1:0]             period_w;
  logic [NPAIR-1:0][CNT_W-1:0]  duty_w;
  logic [DT_W-1:0]              dead_w;
  logic                         dlock_w;
  logic [NOUT-1:0]              fmask_w;
  logic                         wrap_w, reload_w;
  logic [NPAIR-1:0]             raw_w, hi_w, lo_w;
  logic [NOUT-1:0]              drive_w;
  logic                         fault_w;
  logic                         en_w;

  mcpwm_regs #(.CNT_W(CNT_W), .DT_W(DT_W), .NPAIR(NPAIR), .DATA_W(DATA_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .reload_i(reload_w), .ctrl_o(ctrl_w), .period_o(period_w), .duty_o(duty_w),
    .dead_o(dead_w), .dead_lock_o(dlock_w), .fmask_o(fmask_w), .irq_o(reload_irq)
  );

  mcpwm_timebase #(.CNT_W(CNT_W), .NPAIR(NPAIR)) tb_i (
    .clk(clk), .rst_n(rst_n), .en_i(ctrl_w.en), .center_i(ctrl_w.center),
    .rl_sel_i(ctrl_w.rl_sel), .period_buf_i(period_w), .duty_buf_i(duty_w),
    .wrap_o(wrap_w), .reload_o(reload_w), .sync_o(adc_sync), .raw_o(raw_w)
  );

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    mcpwm_deadband #(.DT_W(DT_W)) db_i (
      .clk(clk), .rst_n(rst_n), .raw_i(raw_w[k]), .dead_i(dead_w),
      .hi_o(hi_w[k]), .lo_o(lo_w[k])
    );
    assign drive_w[2*k]   = hi_w[k];
    assign drive_w[2*k+1] = lo_w[k];
  end

  mcpwm_fault fault_i0 (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_in), .pstart_i(wrap_w), .active_o(fault_w)
  );

  assign en_w    = ctrl_w.en;
  assign pwm_out = drive_w & ~(fmask_w & {NOUT{fault_w}}) & {NOUT{en_w}};
endmodule

// File: rtl/mcpwm_sva.sv
`timescale 1ns/1ps
module mcpwm_sva #(
  parameter int unsigned NPAIR  = 3,
  parameter int unsigned DT_W   = 4,
  parameter int unsigned DATA_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [2:0]         wr_addr,
  input logic [DATA_W-1:0]  wr_data,
  input logic               fault_in,
  input logic [2*NPAIR-1:0] pwm_out,
  input logic               adc_sync,
  input logic               reload_irq,
  input logic               en,
  input logic [2*NPAIR-1:0] fmask,
  input logic [DT_W-1:0]    dead,
  input logic               dead_locked
);
  logic [2:0] age_q;
  logic       clr_wr;
  logic       unused_wd;

  assign unused_wd = ^wr_data[DATA_W-1:1];
  assign clr_wr    = wr_en && (wr_addr == 3'd7) && wr_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               age_q <= '0;
    else if (age_q != 3'd4)   age_q <= age_q + 3'd1;
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_chk
    a_r5_pair_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pwm_out[2*k] && pwm_out[2*k+1]));
  end

  a_r12_idle_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !adc_sync);

  a_r7_irq_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reload_irq) |-> adc_sync);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_irq && !clr_wr) |=> reload_irq);

  a_r9_fault_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ((age_q == 3'd4) && $past(fault_in, 3) && $past(fault_in, 2) && $past(fault_in) && fault_in)
      |-> ((pwm_out & fmask) == '0));

  a_r11_dead_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    dead_locked |=> $stable(dead));
endmodule

bind mcpwm_top mcpwm_sva #(.NPAIR(NPAIR), .DT_W(DT_W), .DATA_W(DATA_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .fault_in(fault_in), .pwm_out(pwm_out), .adc_sync(adc_sync), .reload_irq(reload_irq),
  .en(en_w), .fmask(fmask_w), .dead(dead_w), .dead_locked(dlock_w)
);

// File: tb/mcpwm_top_tb_top.sv
`timescale 1ns/1ps
module mcpwm_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [15:0] wr_data;
  logic        fault_in;
  logic [5:0]  pwm_out;
  logic        adc_sync;
  logic        reload_irq;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  mcpwm_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .fault_in(fault_in), .pwm_out(pwm_out), .adc_sync(adc_sync), .reload_irq(reload_irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a;
    wr_data = d;
    wr_en   = 1'b1;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; fault_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_sync();
    @(negedge clk);
    while (!adc_sync) @(negedge clk);
  endtask

  task automatic wait_irq();
    while (!reload_irq) @(negedge clk);
  endtask

  // Window of one period, shifted by the two output pipeline stages.
  task automatic measure(input int pair, input int len, output int hi, output int lo, output int off);
    hi = 0; lo = 0; off = 0;
    wait_sync();
    repeat (2) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (pwm_out[2*pair])   hi++;
      if (pwm_out[2*pair+1]) lo++;
      if (!pwm_out[2*pair] && !pwm_out[2*pair+1]) off++;
      @(negedge clk);
    end
  endtask

  task automatic spacing(output int n);
    wait_sync();
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!adc_sync);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hi, lo, off, n, d, ex;
    do_reset();
    // R1 reset state
    check(pwm_out == 6'd0, "R1 outputs", pwm_out, 0);
    check(reload_irq == 1'b0, "R1 irq", reload_irq, 0);
    check(adc_sync == 1'b0, "R1 sync", adc_sync, 0);

    // R2 R4 edge-aligned sweep, P=8, reload every period
    wr(3'd1, 16'd8);
    wr(3'd0, 16'h0001);
    spacing(n);
    check(n == 8, "R13 edge period spacing", n, 8);
    for (int s = 0; s < 10; s++) begin
      for (int k = 0; k < 3; k++) wr(3'(2 + k), 16'((s + k) % 10));
      wait_sync(); wait_sync();
      for (int k = 0; k < 3; k++) begin
        d  = (s + k) % 10;
        ex = (d >= 8) ? 8 : d;
        measure(k, 8, hi, lo, off);
        check(hi == ex, "R2 R4 edge high time", hi, ex);
        check(lo == 8 - ex, "R2 edge low time", lo, 8 - ex);
      end
    end

    // R3 R4 center-aligned sweep, P=5
    wr(3'd1, 16'd5);
    wr(3'd0, 16'h0003);
    wait_sync(); wait_sync(); wait_sync();
    spacing(n);
    check(n == 10, "R3 center period spacing", n, 10);
    for (int s = 0; s < 7; s++) begin
      for (int k = 0; k < 3; k++) wr(3'(2 + k), 16'((s + k) % 7));
      wait_sync(); wait_sync();
      for (int k = 0; k < 3; k++) begin
        d  = (s + k) % 7;
        ex = (d == 0) ? 0 : ((d >= 5) ? 10 : 2 * d - 1);
        measure(k, 10, hi, lo, off);
        check(hi == ex, "R3 R4 center high time", hi, ex);
        check(lo == 10 - ex, "R3 center low time", lo, 10 - ex);
      end
    end

    // R7 reload interval sweep N=1..16, P=2
    wr(3'd1, 16'd2);
    for (int nn = 1; nn <= 16; nn++) begin
      wr(3'd0, 16'(((nn - 1) << 2) | 1));
      wr(3'd7, 16'd1);
      wait_irq();
      wr(3'd7, 16'd1);
      check(reload_irq == 1'b0, "R8 clear", reload_irq, 0);
      n = 0;
      forever begin
        if (adc_sync) n++;
        if (reload_irq) break;
        @(negedge clk);
      end
      check(n == nn, "R7 periods per reload", n, nn);
      check(adc_sync == 1'b1, "R7 irq with sync", adc_sync, 1);
    end

    // R6 double buffering, P=4, N=3
    wr(3'd1, 16'd4);
    wr(3'd2, 16'd1);
    wr(3'd0, 16'h0009);
    wr(3'd7, 16'd1);
    wait_irq();
    wr(3'd7, 16'd1);
    wait_irq();
    wr(3'd2, 16'd3);
    wr(3'd7, 16'd1);
    measure(0, 4, hi, lo, off);
    check(hi == 1, "R6 old duty before reload", hi, 1);
    wait_irq();
    measure(0, 4, hi, lo, off);
    check(hi == 3, "R6 new duty after reload", hi, 3);

    // R8 clear colliding with reload, N=1, P=4
    wr(3'd0, 16'h0001);
    wait_sync(); wait_sync();
    wait_sync();
    repeat (3) @(negedge clk);
    wr_addr = 3'd7; wr_data = 16'd1; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check(adc_sync == 1'b1, "R8 collision aligned", adc_sync, 1);
    check(reload_irq == 1'b1, "R8 reload wins", reload_irq, 1);
    wr(3'd7, 16'd1);
    check(reload_irq == 1'b0, "R8 clear next cycle", reload_irq, 0);

    // R12 disable
    wr(3'd0, 16'h0000);
    repeat (2) @(negedge clk);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out != 6'd0 || adc_sync) n++;
      @(negedge clk);
    end
    check(n == 0, "R12 disabled quiet", n, 0);

    // R5 R11 dead time with lock
    do_reset();
    wr(3'd1, 16'd10);
    wr(3'd2, 16'd5);
    wr(3'd5, 16'd2);
    wr(3'd5, 16'd0);
    wr(3'd0, 16'h0001);
    wait_sync();
    measure(0, 10, hi, lo, off);
    check(hi == 3, "R5 R11 high with dead time", hi, 3);
    check(lo == 3, "R5 R11 low with dead time", lo, 3);
    check(off == 4, "R5 both off cycles", off, 4);

    // R9 R10 R11 fault masking
    do_reset();
    wr(3'd1, 16'd40);
    wr(3'd2, 16'd40);
    wr(3'd3, 16'd40);
    wr(3'd4, 16'd0);
    wr(3'd6, 16'h0003);
    wr(3'd6, 16'h003C);
    wr(3'd0, 16'h0001);
    wait_sync(); wait_sync();
    repeat (3) @(negedge clk);
    check(pwm_out == 6'h25, "R4 full and zero duty", pwm_out, 6'h25);
    fault_in = 1'b1;
    repeat (5) @(negedge clk);
    check(pwm_out == 6'h24, "R9 R11 masked outputs off", pwm_out, 6'h24);
    wait_sync();
    repeat (2) @(negedge clk);
    fault_in = 1'b0;
    repeat (6) @(negedge clk);
    check(pwm_out == 6'h24, "R10 held until period start", pwm_out, 6'h24);
    wait_sync();
    repeat (3) @(negedge clk);
    check(pwm_out == 6'h25, "R10 recovered", pwm_out, 6'h25);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule